// File: doc/BRIEF.md
# Programmable ADC Channel Sequencer

This block is the digital control that picks the multiplexer channel and the input configuration for every conversion of an eight-channel sampling ADC. The configuration is a single-ended/differential select, a three-bit channel address, a unipolar/bipolar select and a gain select. Mode inputs choose where that configuration comes from. It can come from the configuration pins, held by a write strobe. It can come from a free-running scan over all eight channels. It can come from a stored list of up to sixteen entries that the block steps through one conversion at a time.

A fourth mode lets a host fill the stored list and read it back over a shared parallel bus. Each write or read strobe moves a location pointer forward by one. While this mode is active the busy output is held low, so the host cannot start a conversion. All strobes are sampled on the block clock. The converter reports the start of a conversion by raising `conv_busy`, and the configuration for the next conversion changes one clock after that rising edge.

Top module: `adcseq_ctrl`

## Requirements
- R1: Mode decode: `mode_m1`=0 with `scan_en`=0 is direct mode, `mode_m1`=0 with `scan_en`=1 is scan mode, `mode_m1`=1 with `mode_m0`=1 is sequence-run mode, and `mode_m1`=1 with `mode_m0`=0 is program/readback mode. `scan_en` has no effect while `mode_m1` is 1. Reset leaves every configuration output at 0, `rb_data` at 0 and `busy_n` at 1.
- R2: `busy_n` is 0 in every cycle of program/readback mode. In all other modes it equals the inverse of `conv_busy`.
- R3: In direct mode, while `wr_n` is 0 the configuration outputs follow the configuration pins in the same cycle. While `wr_n` is 1 they hold the pin values from the last clock edge at which `wr_n` was 0.
- R4: In scan mode `cfg_addr` starts at 0 after reset and steps by one, modulo 8, one clock after each rising edge of `conv_busy`. `cfg_diff` is 0, and `cfg_bip` and `cfg_pga` follow their pins.
- R5: In program mode, a rising edge of `wr_n` stores {`in_diff`, `in_addr`, `in_bip`, `in_pga`, `in_eos`} into the location under the pointer and advances the pointer by one. The pointer wraps from location 15 to 0.
- R6: In readback mode, while `rd_n` and `cs_n` are both 0, `rb_data` carries the entry under the pointer: bit 6 differential, bits 5..3 address, bit 2 bipolar, bit 1 gain, bit 0 end-of-sequence. Otherwise `rb_data` is 0. A rising edge of `rd_n` with `cs_n` at 0 advances the pointer, wrapping after location 15.
- R7: A read strobe while `cs_n` is 1 drives nothing onto `rb_data` and leaves the pointer unchanged.
- R8: Entering or leaving program/readback mode sets the pointer to location 0.
- R9: In sequence-run mode the configuration outputs show the entry under the pointer. Each rising edge of `conv_busy` advances the pointer, and after an entry whose end-of-sequence bit is 1 the pointer returns to 0.
- R10: In sequence-run mode, when no end-of-sequence bit is set, the pointer returns to 0 after location 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_m1 | input | 1 | Mode select, high bit |
| mode_m0 | input | 1 | Mode select, low bit |
| scan_en | input | 1 | Selects scan instead of direct when mode_m1 is 0 |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cs_n | input | 1 | Chip select for readback, active low |
| conv_busy | input | 1 | High while the converter is converting; the rising edge marks a conversion start |
| in_diff | input | 1 | Differential select pin |
| in_addr | input | 3 | Channel address pins |
| in_bip | input | 1 | Bipolar select pin |
| in_pga | input | 1 | Gain select pin |
| in_eos | input | 1 | End-of-sequence flag for programming |
| cfg_diff | output | 1 | Active differential select |
| cfg_addr | output | 3 | Active channel address |
| cfg_bip | output | 1 | Active bipolar select |
| cfg_pga | output | 1 | Active gain select |
| rb_data | output | 7 | Readback bus |
| busy_n | output | 1 | Busy to the host, low while converting or in program mode |

## Verification
The bench builds the block with its default depth of sixteen locations and eight channels. At that depth a list of sixteen entries can be written, read back and run within a few hundred cycles. This covers both wrap paths of the pointer: the one after location 15 and the one after an end-of-sequence entry. It also covers the scan counter passing from 7 back to 0.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CH_AW = 3;

    typedef struct packed {
        logic             diff;
        logic [CH_AW-1:0] addr;
        logic             bip;
        logic             pga;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic eos;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef enum logic [1:0] {
        MD_DIRECT = 2'd0,
        MD_SCAN   = 2'd1,
        MD_RUN    = 2'd2,
        MD_PROG   = 2'd3
    } mode_t;

endpackage

// File: rtl/adcseq_mode.sv
module adcseq_mode
    import adcseq_pkg::*;
(
    input  logic  m1,
    input  logic  m0,
    input  logic  scan_en,
    output mode_t mode
);
    always_comb begin
        if (!m1)     mode = scan_en ? MD_SCAN : MD_DIRECT;
        else if (m0) mode = MD_RUN;
        else         mode = MD_PROG;
    end
endmodule

// File: rtl/adcseq_edge.sv
module adcseq_edge #(
    parameter int            W    = 3,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/adcseq_mem.sv
module adcseq_mem
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  entry_t        wdata,
    input  logic [PW-1:0] raddr,
    output entry_t        rdata
);
    entry_t [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_m1,
    input  logic             mode_m0,
    input  logic             scan_en,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cs_n,
    input  logic             conv_busy,
    input  logic             in_diff,
    input  logic [CH_AW-1:0] in_addr,
    input  logic             in_bip,
    input  logic             in_pga,
    input  logic             in_eos,
    output logic             cfg_diff,
    output logic [CH_AW-1:0] cfg_addr,
    output logic             cfg_bip,
    output logic             cfg_pga,
    output logic [ENTRY_W-1:0] rb_data,
    output logic             busy_n
);
    localparam int            PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [CH_AW-1:0] scan;
        cfg_t             lat;
        logic             prog;
    } st_t;

    st_t    st_d, st_q;
    mode_t  mode;
    logic   busy_rise, wr_rise, rd_rise;
    logic   prog_now, mem_we;
    cfg_t   pin_cfg, act_cfg;
    entry_t cur;
    logic [PW-1:0] ptr_mon;

    adcseq_mode u_mode (
        .m1      (mode_m1),
        .m0      (mode_m0),
        .scan_en (scan_en),
        .mode    (mode)
    );

    adcseq_edge #(.W(3), .INIT(3'b011)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({conv_busy, wr_n, rd_n}),
        .rise  ({busy_rise, wr_rise, rd_rise})
    );

    assign pin_cfg  = '{diff: in_diff, addr: in_addr, bip: in_bip, pga: in_pga};
    assign prog_now = (mode == MD_PROG);
    assign mem_we   = prog_now && st_q.prog && wr_rise;

    adcseq_mem #(.DEPTH(DEPTH), .PW(PW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (st_q.ptr),
        .wdata ('{cfg: pin_cfg, eos: in_eos}),
        .raddr (st_q.ptr),
        .rdata (cur)
    );

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.prog = prog_now;
        if (!wr_n) st_d.lat = pin_cfg;

        if (prog_now != st_q.prog) begin
            st_d.ptr = '0;
        end else if (prog_now) begin
            if (wr_rise || (rd_rise && !cs_n)) st_d.ptr = ptr_inc(st_q.ptr);
        end else if (mode == MD_RUN && busy_rise) begin
            st_d.ptr = cur.eos ? '0 : ptr_inc(st_q.ptr);
        end

        if (mode == MD_SCAN && busy_rise) st_d.scan = st_q.scan + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (mode)
            MD_SCAN: act_cfg = '{diff: 1'b0, addr: st_q.scan, bip: in_bip, pga: in_pga};
            MD_RUN:  act_cfg = cur.cfg;
            default: act_cfg = wr_n ? st_q.lat : pin_cfg;
        endcase
    end

    assign cfg_diff = act_cfg.diff;
    assign cfg_addr = act_cfg.addr;
    assign cfg_bip  = act_cfg.bip;
    assign cfg_pga  = act_cfg.pga;
    assign rb_data  = (prog_now && !rd_n && !cs_n) ? cur : '0;
    assign busy_n   = !(conv_busy || prog_now);
    assign ptr_mon  = st_q.ptr;
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_m1,
    input logic          mode_m0,
    input logic          scan_en,
    input logic          wr_n,
    input logic          rd_n,
    input logic          cs_n,
    input logic          conv_busy,
    input logic          cfg_diff,
    input logic [2:0]    cfg_addr,
    input logic          cfg_bip,
    input logic          cfg_pga,
    input logic [6:0]    rb_data,
    input logic          busy_n,
    input logic [PW-1:0] ptr_mon
);
    logic prog_sel, scan_sel, direct_sel;
    assign prog_sel   = mode_m1 && !mode_m0;
    assign scan_sel   = !mode_m1 && scan_en;
    assign direct_sel = !mode_m1 && !scan_en;

    a_r2_busy_low_prog: assert property (@(posedge clk) disable iff (!rst_n)
        prog_sel |-> !busy_n);

    a_r4_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_sel && $rose(conv_busy)) |=> (!scan_sel || cfg_addr == $past(cfg_addr) + 3'd1));

    a_r3_direct_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_sel && wr_n && $past(wr_n) && $past(direct_sel))
        |-> $stable({cfg_diff, cfg_addr, cfg_bip, cfg_pga}));

    a_r6_rb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_sel && !rd_n && !cs_n) |-> rb_data == 7'd0);

    a_r8_ptr_enter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_sel) |=> ptr_mon == '0);

    a_r8_ptr_leave: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_sel) |=> ptr_mon == '0);
endmodule

bind adcseq_ctrl adcseq_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_m1   (mode_m1),
    .mode_m0   (mode_m0),
    .scan_en   (scan_en),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .cs_n      (cs_n),
    .conv_busy (conv_busy),
    .cfg_diff  (cfg_diff),
    .cfg_addr  (cfg_addr),
    .cfg_bip   (cfg_bip),
    .cfg_pga   (cfg_pga),
    .rb_data   (rb_data),
    .busy_n    (busy_n),
    .ptr_mon   (ptr_mon)
);

// File: tb/sim_adcseq_ctrl.sv
`timescale 1ns/1ps
module sim_adcseq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_m1 = 0, mode_m0 = 0, scan_en = 0;
    logic wr_n = 1, rd_n = 1, cs_n = 1, conv_busy = 0;
    logic in_diff = 0, in_bip = 0, in_pga = 0, in_eos = 0;
    logic [2:0] in_addr = 0;
    logic cfg_diff, cfg_bip, cfg_pga, busy_n;
    logic [2:0] cfg_addr;
    logic [6:0] rb_data;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [6:0] exp_mem [16];
    int exp_ptr = 0;

    always #5 clk = ~clk;

    adcseq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_m1(mode_m1), .mode_m0(mode_m0),
        .scan_en(scan_en), .wr_n(wr_n), .rd_n(rd_n), .cs_n(cs_n),
        .conv_busy(conv_busy), .in_diff(in_diff), .in_addr(in_addr),
        .in_bip(in_bip), .in_pga(in_pga), .in_eos(in_eos),
        .cfg_diff(cfg_diff), .cfg_addr(cfg_addr), .cfg_bip(cfg_bip),
        .cfg_pga(cfg_pga), .rb_data(rb_data), .busy_n(busy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [5:0] cfg_now();
        return {cfg_diff, cfg_addr, cfg_bip, cfg_pga};
    endfunction

    function automatic int next_ptr(input int p);
        return (exp_mem[p][0] || p == 15) ? 0 : p + 1;
    endfunction

    task automatic set_pins(input logic [6:0] e);
        {in_diff, in_addr, in_bip, in_pga, in_eos} = e;
    endtask

    task automatic prog_write(input logic [6:0] e);
        set_pins(e);
        wr_n = 0; tick();
        wr_n = 1; tick();
        exp_mem[exp_ptr] = e;
        exp_ptr = (exp_ptr + 1) % 16;
    endtask

    task automatic read_check(input string req);
        rd_n = 0; #1;
        check(req, rb_data, exp_mem[exp_ptr]);
        tick();
        rd_n = 1; tick();
        exp_ptr = (exp_ptr + 1) % 16;
    endtask

    task automatic convert();
        conv_busy = 1; tick();
        conv_busy = 0; tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [6:0] e;
        logic [2:0] sa;
        void'($urandom(32'h1853));
        repeat (3) tick();
        rst_n = 1; tick();

        // R1: reset state
        check("R1 reset cfg", cfg_now(), 0);
        check("R1 reset rb", rb_data, 0);
        check("R1 reset busy_n", busy_n, 1);

        // R4: scan mode, diff pin ignored
        scan_en = 1; in_diff = 1; in_bip = 1; in_pga = 0; #1;
        check("R4 scan start", cfg_now(), {1'b0, 3'd0, 1'b1, 1'b0});
        sa = 0;
        for (int i = 0; i < 11; i++) begin
            repeat ($urandom_range(0, 3)) tick();
            convert();
            sa = sa + 3'd1;
            check("R4 scan step", cfg_now(), {1'b0, sa, 1'b1, 1'b0});
        end
        // R2 outside program mode
        conv_busy = 1; #1;
        check("R2 busy follows", busy_n, 0);
        tick(); conv_busy = 0; tick();
        sa = sa + 3'd1;

        // R3: direct mode, transparent and hold
        scan_en = 0;
        for (int i = 0; i < 8; i++) begin
            e = 7'($urandom);
            set_pins(e);
            wr_n = 0; #1;
            check("R3 transparent", cfg_now(), e[6:1]);
            tick();
            wr_n = 1; tick();
            set_pins(~e); #1;
            check("R3 hold", cfg_now(), e[6:1]);
        end
        // R1: scan_en ignored while mode_m1 high (run mode shows memory, all zero)
        mode_m1 = 1; mode_m0 = 1; scan_en = 1; tick();
        check("R1 scan_en ignored", cfg_now(), 0);
        scan_en = 0;

        // R5/R2/R8: program 16 random entries
        mode_m0 = 0; tick();
        exp_ptr = 0;
        check("R2 busy low prog", busy_n, 0);
        conv_busy = 1; #1;
        check("R2 busy low prog conv", busy_n, 0);
        conv_busy = 0;
        for (int i = 0; i < 16; i++) begin
            e = 7'($urandom);
            e[0] = ($urandom_range(0, 3) == 0);
            prog_write(e);
        end
        // R7: read strobe without chip select
        cs_n = 1; rd_n = 0; #1;
        check("R7 no drive", rb_data, 0);
        tick(); rd_n = 1; tick();
        cs_n = 0;
        // R6: read back all, then wrap (R5 write pointer wrapped to 0 too)
        for (int i = 0; i < 17; i++) read_check("R6 readback");
        // R8: pointer reset on leave/enter
        prog_write(7'h55); prog_write(7'h2a);
        mode_m0 = 1; tick(); mode_m0 = 0; tick();
        exp_ptr = 0;
        read_check("R8 ptr cleared");

        // R9: run the programmed list
        mode_m0 = 1; tick(); exp_ptr = 0;
        check("R2 busy idle run", busy_n, 1);
        for (int i = 0; i < 40; i++) begin
            check("R9 run cfg", cfg_now(), exp_mem[exp_ptr][6:1]);
            convert();
            exp_ptr = next_ptr(exp_ptr);
        end
        // R9 directed: end flag on entry 2
        mode_m0 = 0; tick(); exp_ptr = 0;
        for (int i = 0; i < 16; i++) prog_write({i[3:0], 2'b00, (i == 2)});
        mode_m0 = 1; tick(); exp_ptr = 0;
        for (int i = 0; i < 4; i++) convert();
        check("R9 eos wrap", cfg_now(), exp_mem[1][6:1]);

        // R10: no end flag, wrap after 15
        mode_m0 = 0; tick(); exp_ptr = 0;
        for (int i = 0; i < 16; i++) prog_write({i[2:0], i[3], 2'b10, 1'b0});
        mode_m0 = 1; tick(); exp_ptr = 0;
        for (int i = 0; i < 20; i++) begin
            check("R10 run wrap", cfg_now(), exp_mem[exp_ptr][6:1]);
            convert();
            exp_ptr = next_ptr(exp_ptr);
        end

        // R4: scan counter kept its place across other modes
        mode_m1 = 0; scan_en = 1; in_diff = 0; in_bip = 0; in_pga = 1; #1;
        check("R4 scan resume", cfg_now(), {1'b0, sa, 1'b0, 1'b1});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule